// File: doc/BRIEF.md
# ADC Sample Conditioner

This block sits at the head of a pulse-processing filter chain. It takes raw signed two's-complement converter samples and hands the filters an unsigned, linearity-corrected word. Every accepted sample goes through two registered steps: a correction step and a polarity-mapping step.

In the correction step, the two lowest sample bits are discarded. A 16-entry table of 4-bit words, indexed by sample bits 8 down to 5, supplies a nibble in 2.2 fixed-point format that fills their place. The word therefore grows from 14 to 16 bits, and the bottom two bits are fractional. In the mapping step, the signed word becomes unsigned by bit inversion, not by an absolute value, so the full dynamic range is kept. Positive-polarity signals get their MSB inverted. Negative-polarity signals get every bit below the MSB inverted. A bypass mode passes the word through unchanged.

The table can be rewritten at run time through a small write port. Calibration software works out the table contents; that work is outside this block.

Top module: `adc_sample_cond`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` is high exactly 2 clock cycles after `in_valid` was high, and is low otherwise.
- R3: In bypass, `out_data` equals `{in_sample[13:2], T[in_sample[8:5]]}`, where T is the correction table.
- R4: With `in_mode` = 2'b00 (positive polarity), `out_data` is the corrected word with only bit 15 inverted. This equals adding 32768 modulo 2^16.
- R5: With `in_mode` = 2'b01 (negative polarity), `out_data` is the corrected word with bits 14..0 inverted and bit 15 kept. No +1 is added.
- R6: `in_mode` = 2'b10 and `in_mode` = 2'b11 both select bypass.
- R7: The table index comes only from sample bits 8..5. Samples that differ in other bits read the same entry.
- R8: When `tbl_we` is high at a clock edge, entry `tbl_addr` takes the value `tbl_data`. A sample accepted at that same edge uses the old entry. Samples accepted at later edges use the new entry.
- R9: The mode is captured together with each valid sample. A mode change affects only samples accepted from then on, never samples already in the pipeline.
- R10: While `out_valid` is low, `out_data` holds its last value.
- R11: After reset, every table entry is 4'b0110, which is 1.50 in 2.2 format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 14 | Signed two's-complement sample |
| in_mode | input | 2 | 00 positive polarity, 01 negative polarity, 1x bypass |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 4 | Table entry to write |
| tbl_data | input | 4 | New 2.2 correction nibble |
| out_valid | output | 1 | Conditioned sample strobe |
| out_data | output | 16 | Conditioned unsigned sample, 2 fractional bits |

## Verification
On every cycle, the assertions check the two-cycle valid latency and that idle cycles hold the output. They also check the integer part of the output against the sample from two cycles earlier in each of the three modes, which covers MSB inversion, lower-bit inversion and pass-through. Only the bench's scenarios can show the fractional nibble. That means the table reset contents, the address slice, the old/new entry choice when a write and a sample meet at the same edge, and modes that alternate sample by sample while the pipeline is full. The bench sweeps every 14-bit sample code in each mode against an arithmetic model.

// File: rtl/adc_cond_pkg.sv
package adc_cond_pkg;

   typedef enum logic [1:0] {
      MODE_POS     = 2'b00,
      MODE_NEG     = 2'b01,
      MODE_BYP     = 2'b10,
      MODE_BYP_ALT = 2'b11
   } cond_mode_e;

endpackage

// File: rtl/adc_cond_lut.sv
module adc_cond_lut #(
   parameter int SEL_W     = 4,
   parameter int NIB_W     = 4,
   parameter int RESET_NIB = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_addr,
   input  logic [NIB_W-1:0] wr_nib,
   input  logic [SEL_W-1:0] rd_addr,
   output logic [NIB_W-1:0] rd_nib
);
   localparam int DEPTH = 1 << SEL_W;

   logic [DEPTH-1:0][NIB_W-1:0] cells;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [NIB_W-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= NIB_W'(RESET_NIB);
         else if (wr_en && (wr_addr == SEL_W'(g)))
            cell_q <= wr_nib;
      end
      assign cells[g] = cell_q;
   end

   assign rd_nib = cells[rd_addr];
endmodule

// File: rtl/adc_cond_fix.sv
module adc_cond_fix
   import adc_cond_pkg::*;
#(
   parameter int KEEP_W = 12,
   parameter int NIB_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [KEEP_W-1:0]       kept_bits,
   input  logic [NIB_W-1:0]        nib,
   input  cond_mode_e              in_mode,
   output logic                    s1_valid,
   output logic [KEEP_W+NIB_W-1:0] s1_word,
   output cond_mode_e              s1_mode
);
   localparam int WORD_W = KEEP_W + NIB_W;

   logic [WORD_W-1:0] corrected;
   assign corrected = {kept_bits, nib};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_word  <= '0;
         s1_mode  <= MODE_POS;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_word <= corrected;
            s1_mode <= in_mode;
         end
      end
   end
endmodule

// File: rtl/adc_cond_map.sv
module adc_cond_map
   import adc_cond_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s1_valid,
   input  logic [WORD_W-1:0] s1_word,
   input  cond_mode_e        s1_mode,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data
);
   localparam logic [WORD_W-1:0] MSB_ONLY = {1'b1, {(WORD_W-1){1'b0}}};
   localparam logic [WORD_W-1:0] BELOW_MSB = {1'b0, {(WORD_W-1){1'b1}}};

   logic [WORD_W-1:0] flip_mask;
   logic [WORD_W-1:0] mapped;

   always_comb begin
      unique case (s1_mode)
         MODE_POS:     flip_mask = MSB_ONLY;
         MODE_NEG:     flip_mask = BELOW_MSB;
         MODE_BYP,
         MODE_BYP_ALT: flip_mask = '0;
         default:      flip_mask = '0;
      endcase
   end

   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      assign mapped[b] = s1_word[b] ^ flip_mask[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid)
            out_data <= mapped;
      end
   end
endmodule

// File: rtl/adc_sample_cond.sv
module adc_sample_cond
   import adc_cond_pkg::*;
#(
   parameter int IN_W      = 14,
   parameter int DROP_W    = 2,
   parameter int FRAC_W    = 2,
   parameter int SEL_LSB   = 5,
   parameter int SEL_W     = 4,
   parameter int RESET_NIB = 6,
   localparam int NIB_W    = DROP_W + FRAC_W,
   localparam int OUT_W    = IN_W + FRAC_W,
   localparam int KEEP_W   = IN_W - DROP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [IN_W-1:0]   in_sample,
   input  logic [1:0]        in_mode,
   input  logic              tbl_we,
   input  logic [SEL_W-1:0]  tbl_addr,
   input  logic [NIB_W-1:0]  tbl_data,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_data
);
   if (DROP_W < 1) begin : g_bad_drop
      $error("adc_sample_cond: DROP_W must be at least 1");
   end
   if (FRAC_W < 0) begin : g_bad_frac
      $error("adc_sample_cond: FRAC_W must not be negative");
   end
   if (SEL_LSB + SEL_W > IN_W - 1) begin : g_bad_sel
      $error("adc_sample_cond: table index slice must lie below the sign bit");
   end
   if (RESET_NIB < 0 || RESET_NIB >= (1 << NIB_W)) begin : g_bad_reset
      $error("adc_sample_cond: RESET_NIB does not fit the nibble width");
   end

   logic [NIB_W-1:0]  nib;
   logic              s1_valid;
   logic [OUT_W-1:0]  s1_word;
   cond_mode_e        s1_mode;
   logic              drop_unused;

   assign drop_unused = ^in_sample[DROP_W-1:0];

   adc_cond_lut #(
      .SEL_W     (SEL_W),
      .NIB_W     (NIB_W),
      .RESET_NIB (RESET_NIB)
   ) u_lut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_we),
      .wr_addr (tbl_addr),
      .wr_nib  (tbl_data),
      .rd_addr (in_sample[SEL_LSB +: SEL_W]),
      .rd_nib  (nib)
   );

   adc_cond_fix #(
      .KEEP_W (KEEP_W),
      .NIB_W  (NIB_W)
   ) u_fix (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .kept_bits (in_sample[IN_W-1:DROP_W]),
      .nib       (nib),
      .in_mode   (cond_mode_e'(in_mode)),
      .s1_valid  (s1_valid),
      .s1_word   (s1_word),
      .s1_mode   (s1_mode)
   );

   adc_cond_map #(
      .WORD_W (OUT_W)
   ) u_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .s1_valid  (s1_valid),
      .s1_word   (s1_word),
      .s1_mode   (s1_mode),
      .out_valid (out_valid),
      .out_data  (out_data)
   );
endmodule

// File: rtl/adc_sample_cond_chk.sv
module adc_sample_cond_chk #(
   parameter int KEEP_W = 12,
   parameter int OUT_W  = 16,
   parameter int NIB_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [KEEP_W-1:0] hi_bits,
   input logic [1:0]        in_mode,
   input logic              out_valid,
   input logic [OUT_W-1:0]  out_data
);
   logic [1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         age <= '0;
      else if (age != 2'd3)
         age <= age + 2'd1;
   end

   // R2: valid emerges two cycles after it entered
   assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

   // R4: positive polarity flips the sign bit only
   assert_pos_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(in_valid, 2) && $past(in_mode, 2) == 2'b00) |->
      (out_data[OUT_W-1] != $past(hi_bits[KEEP_W-1], 2) &&
       out_data[OUT_W-2:NIB_W] == $past(hi_bits[KEEP_W-2:0], 2)));

   // R5: negative polarity flips everything below the sign bit
   assert_neg_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(in_valid, 2) && $past(in_mode, 2) == 2'b01) |->
      (out_data[OUT_W-1] == $past(hi_bits[KEEP_W-1], 2) &&
       out_data[OUT_W-2:NIB_W] == ~$past(hi_bits[KEEP_W-2:0], 2)));

   // R6: both bypass codes leave the integer bits untouched
   assert_bypass_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(in_valid, 2) && $past(in_mode[1], 2)) |->
      (out_data[OUT_W-1:NIB_W] == $past(hi_bits, 2)));

   // R10: idle cycles keep the output word
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1 && !out_valid) |-> $stable(out_data));
endmodule

bind adc_sample_cond adc_sample_cond_chk #(
   .KEEP_W (KEEP_W),
   .OUT_W  (OUT_W),
   .NIB_W  (NIB_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .hi_bits   (in_sample[IN_W-1:DROP_W]),
   .in_mode   (in_mode),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/test_adc_sample_cond.sv
`timescale 1ns/1ps
module test_adc_sample_cond;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [13:0] in_sample;
   logic [1:0]  in_mode;
   logic        tbl_we;
   logic [3:0]  tbl_addr;
   logic [3:0]  tbl_data;
   logic        out_valid;
   logic [15:0] out_data;

   always #2 clk = ~clk;

   adc_sample_cond i_adc_sample_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sample (in_sample),
      .in_mode   (in_mode),
      .tbl_we    (tbl_we),
      .tbl_addr  (tbl_addr),
      .tbl_data  (tbl_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   int          n_run  = 0;
   int          n_fail = 0;
   bit          done   = 1'b0;
   logic [3:0]  tbl_m [16];
   logic        pv [2];
   logic [15:0] pe [2];
   string       pt [2];
   logic [15:0] last_exp;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_word(input logic [13:0] s, input logic [1:0] m);
      int w;
      w = (int'(s) / 4) * 16 + int'(tbl_m[(int'(s) / 32) % 16]);
      if (m == 2'b00)      w = (w + 32768) % 65536;
      else if (m == 2'b01) w = (w / 32768) * 32768 + (32767 - (w % 32768));
      return 16'(w);
   endfunction

   task automatic step(input bit v, input logic [13:0] s, input logic [1:0] m,
                       input bit we, input logic [3:0] wa, input logic [3:0] wd,
                       input string tag);
      check(out_valid == pv[1], "R2", 32'(out_valid), 32'(pv[1]));
      if (pv[1]) begin
         check(out_data == pe[1], pt[1], 32'(out_data), 32'(pe[1]));
         last_exp = pe[1];
      end else begin
         check(out_data == last_exp, "R10", 32'(out_data), 32'(last_exp));
      end
      pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
      pv[0] = v;     pe[0] = exp_word(s, m); pt[0] = tag;
      in_valid  = v;
      in_sample = s;
      in_mode   = m;
      tbl_we    = we;
      tbl_addr  = wa;
      tbl_data  = wd;
      if (we) tbl_m[wa] = wd;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; in_mode = 2'b00;
      tbl_we = 1'b0; tbl_addr = '0; tbl_data = '0;
      for (int i = 0; i < 16; i++) tbl_m[i] = 4'b0110;
      for (int i = 0; i < 2; i++) begin pv[i] = 1'b0; pe[i] = '0; pt[i] = "none"; end
      last_exp = '0;
      repeat (3) @(negedge clk);
      // R1: outputs cleared while reset is held
      check(out_valid == 1'b0, "R1", 32'(out_valid), 0);
      check(out_data == 16'h0, "R1", 32'(out_data), 0);
      rst_n = 1'b1;

      // R11: reset table contents, full sweep in bypass
      for (int k = 0; k < 16384; k++) step(1, 14'(k), 2'b10, 0, 0, 0, "R11");
      step(0, 0, 2'b10, 0, 0, 0, "R10");
      step(0, 0, 2'b10, 0, 0, 0, "R10");

      // R8: load a new table
      for (int a = 0; a < 16; a++) step(0, 0, 2'b10, 1, 4'(a), 4'((a * 5 + 9) % 16), "R8");
      // R8: write and sample meet at the same edge, then the next sample sees the new entry
      step(1, 14'h0061, 2'b10, 1, 4'd3, 4'hA, "R8");
      step(1, 14'h0061, 2'b10, 0, 0, 0, "R8");
      step(1, 14'h1E7E, 2'b10, 1, 4'd3, 4'h1, "R8");
      step(1, 14'h1E7E, 2'b10, 0, 0, 0, "R8");

      // R7: index uses bits 8..5 only, other bits vary
      for (int k = 0; k < 16; k++) begin
         step(1, 14'((k * 32) + 14'h2A16), 2'b10, 0, 0, 0, "R7");
         step(1, 14'((k * 32) + 14'h1409), 2'b10, 0, 0, 0, "R7");
      end

      // R4, R5, R3: full sweeps with idle gaps
      for (int k = 0; k < 16384; k++) begin
         step(1, 14'(k), 2'b00, 0, 0, 0, "R4");
         if (k % 97 == 0) step(0, 0, 2'b00, 0, 0, 0, "R10");
      end
      for (int k = 0; k < 16384; k++) begin
         step(1, 14'(k), 2'b01, 0, 0, 0, "R5");
         if (k % 89 == 0) step(0, 0, 2'b01, 0, 0, 0, "R10");
      end
      for (int k = 0; k < 16384; k++) step(1, 14'(k), 2'b10, 0, 0, 0, "R3");

      // R6: second bypass code
      for (int k = 0; k < 256; k++) step(1, 14'(k * 61), 2'b11, 0, 0, 0, "R6");

      // R9: mode changes on every sample with the pipeline full
      for (int i = 0; i < 512; i++) step(1, 14'(i * 37 + 5), 2'(i % 4), 0, 0, 0, "R9");

      repeat (3) step(0, 0, 2'b00, 0, 0, 0, "R10");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule